// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each received frame, whether its 48-bit destination address lets the frame through. It keeps a table of sixteen six-byte station addresses, compares a query address against all of them in parallel, and combines the result with a fixed broadcast rule and four mode inputs: promiscuous, receive-all, pass-all-multicast and inverse filtering. The frame length is checked too, and a frame outside the legal length window is refused before any address rule applies.

The table is filled by streaming a 192-byte setup frame into the block one byte per cycle. The frame is split into sixteen 12-byte slots. Only six bytes of each slot carry address data; the others are padding and are dropped. While a load is under way, queries are held off with a ready signal. A query that is taken gives a registered result one cycle later: an accept bit, a flag saying that acceptance came from a mode that disables filtering, and a flag saying that acceptance came from the multicast pass mode.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `res_valid` is 0, `qry_ready` is 1 and every table entry holds the all-zero address, so a legal-length query for address 0 is accepted.
- R2: A legal-length query whose address equals any table entry gives `res_accept` = 1; a unicast address found in no entry, with all modes off, gives `res_accept` = 0. Address byte k is `qry_addr[8k+7:8k]`; byte 0 is the first byte on the wire.
- R3: The address with all 48 bits set is accepted whatever the table holds (inverse mode off).
- R4: When `mode_promisc` or `mode_rx_all` is 1, a legal-length query is accepted and `res_filt_fail` is 1; otherwise `res_filt_fail` is 0.
- R5: When `mode_pass_mcast` is 1 and bit 0 of address byte 0 (`qry_addr[0]`) is 1, a legal-length query is accepted and `res_mcast` is 1; otherwise `res_mcast` is 0.
- R6: When `mode_inverse` is 1, the accept decision formed by R2 to R5 is inverted for a legal-length query; the two flags are not affected.
- R7: During a setup load, byte 12n+p of the frame goes to entry n: p = 0, 1, 4, 5, 8, 9 fill address bytes 0 to 5 in that order, and p = 2, 3, 6, 7, 10, 11 are ignored. A complete load is 192 bytes and replaces all sixteen entries.
- R8: A query with `qry_len` below 14 or above 2044 gives `res_accept` = 0, `res_filt_fail` = 0 and `res_mcast` = 0, whatever the modes (inverse included); 14 and 2044 are legal.
- R9: `qry_ready` is 0 in any cycle with `setup_valid` high and in every cycle between the first and the 192nd byte of a load; a query offered while `qry_ready` is 0 is not taken and produces no result.
- R10: `res_valid` is 1 in exactly the cycle after a cycle with `qry_valid` and `qry_ready` both high, and the result outputs then belong to that query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Setup frame byte present |
| setup_data | input | 8 | Setup frame byte |
| mode_promisc | input | 1 | Accept every frame, raise filter-fail flag |
| mode_rx_all | input | 1 | Accept every frame, raise filter-fail flag |
| mode_pass_mcast | input | 1 | Accept every group address, raise multicast flag |
| mode_inverse | input | 1 | Invert the final accept decision |
| qry_valid | input | 1 | Query present |
| qry_ready | output | 1 | Query can be taken this cycle |
| qry_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| qry_len | input | LEN_W (16) | Frame length in bytes |
| res_valid | output | 1 | Result present |
| res_accept | output | 1 | Frame passes the filter |
| res_filt_fail | output | 1 | Accepted by promiscuous or receive-all mode |
| res_mcast | output | 1 | Accepted by pass-all-multicast mode |

## Verification
Queries are drawn from four address pools: addresses copied from the loaded table, the broadcast address, random unicast and random group addresses; a hit separates table matching from the mode rules, and a group address tells the multicast mode apart from plain matching. Modes are switched on at random so that each one is seen alone and combined with inverse filtering, which shows that inversion acts on the whole decision but not on the flags. Lengths are mostly legal but include the edges 13, 14, 2044 and 2045, which separate the length gate from everything else. Two setup frames of random bytes are loaded, so padding bytes that leaked into the table or entries left over from the first load would give wrong matches, and a query held during a load shows the stall.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ENTRIES = 16,
  parameter int LEN_W   = 16,
  parameter int LEN_MIN = 14,
  parameter int LEN_MAX = 2044
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_valid,
  input  logic [7:0]       setup_data,
  input  logic             mode_promisc,
  input  logic             mode_rx_all,
  input  logic             mode_pass_mcast,
  input  logic             mode_inverse,
  input  logic             qry_valid,
  output logic             qry_ready,
  input  logic [47:0]      qry_addr,
  input  logic [LEN_W-1:0] qry_len,
  output logic             res_valid,
  output logic             res_accept,
  output logic             res_filt_fail,
  output logic             res_mcast
);
  localparam int SLOT = 12;
  localparam int SW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [3:0]    pos_q;
  logic [SW-1:0] slot_q;
  logic [47:0]   tbl [ENTRIES];
  logic [ENTRIES-1:0] hit;
  logic [2:0]    bsel;

  wire loading = (pos_q != 4'd0) || (slot_q != '0);
  assign qry_ready = !loading && !setup_valid;
  assign bsel = {pos_q[3:2], pos_q[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      slot_q <= '0;
    end else if (setup_valid) begin
      if (pos_q == 4'(SLOT - 1)) begin
        pos_q  <= '0;
        slot_q <= (slot_q == SW'(ENTRIES - 1)) ? '0 : slot_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl[e] <= '0;
      else if (setup_valid && slot_q == SW'(e) && !pos_q[1])
        tbl[e][{bsel, 3'b000} +: 8] <= setup_data;
    end
    assign hit[e] = (tbl[e] == qry_addr);
  end

  wire len_ok  = (qry_len >= LEN_W'(LEN_MIN)) && (qry_len <= LEN_W'(LEN_MAX));
  wire ff      = mode_promisc | mode_rx_all;
  wire mf      = mode_pass_mcast & qry_addr[0];
  wire pre_acc = (|hit) | (&qry_addr) | ff | mf;
  wire take    = qry_valid & qry_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_accept    <= 1'b0;
      res_filt_fail <= 1'b0;
      res_mcast     <= 1'b0;
    end else begin
      res_valid <= take;
      if (take) begin
        res_accept    <= len_ok & (pre_acc ^ mode_inverse);
        res_filt_fail <= len_ok & ff;
        res_mcast     <= len_ok & mf;
      end
    end
  end
endmodule

module rx_addr_filter_chk #(
  parameter int LEN_W   = 16,
  parameter int LEN_MIN = 14,
  parameter int LEN_MAX = 2044
) (
  input logic             clk,
  input logic             rst_n,
  input logic             setup_valid,
  input logic             mode_promisc,
  input logic             mode_rx_all,
  input logic             mode_inverse,
  input logic             qry_valid,
  input logic             qry_ready,
  input logic [47:0]      qry_addr,
  input logic [LEN_W-1:0] qry_len,
  input logic             res_valid,
  input logic             res_accept,
  input logic             res_filt_fail,
  input logic             res_mcast
);
  wire take   = qry_valid && qry_ready;
  wire len_ok = (qry_len >= LEN_W'(LEN_MIN)) && (qry_len <= LEN_W'(LEN_MAX));

  // R10
  res_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);
  // R10
  no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !res_valid);
  // R9
  stall_on_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid |-> !qry_ready);
  // R8
  len_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !len_ok) |=> (!res_accept && !res_filt_fail && !res_mcast));
  // R4
  filt_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && len_ok && (mode_promisc || mode_rx_all)) |=> res_filt_fail);
  // R3
  bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && len_ok && (&qry_addr) && !mode_inverse) |=> res_accept);
  // R6
  inverse_promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && len_ok && mode_promisc && mode_inverse) |=> !res_accept);
endmodule

bind rx_addr_filter rx_addr_filter_chk #(
  .LEN_W(LEN_W), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid),
  .mode_promisc(mode_promisc), .mode_rx_all(mode_rx_all),
  .mode_inverse(mode_inverse), .qry_valid(qry_valid), .qry_ready(qry_ready),
  .qry_addr(qry_addr), .qry_len(qry_len), .res_valid(res_valid),
  .res_accept(res_accept), .res_filt_fail(res_filt_fail), .res_mcast(res_mcast)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_valid = 1'b0;
  logic [7:0]  setup_data = '0;
  logic        mode_promisc = 1'b0, mode_rx_all = 1'b0;
  logic        mode_pass_mcast = 1'b0, mode_inverse = 1'b0;
  logic        qry_valid = 1'b0;
  logic        qry_ready;
  logic [47:0] qry_addr = '0;
  logic [15:0] qry_len = 16'd64;
  logic        res_valid, res_accept, res_filt_fail, res_mcast;

  int checks = 0;
  int errors = 0;
  logic [47:0] mtab [16];
  logic [7:0]  sf [192];

  always #2.5 clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_data(setup_data),
    .mode_promisc(mode_promisc), .mode_rx_all(mode_rx_all),
    .mode_pass_mcast(mode_pass_mcast), .mode_inverse(mode_inverse),
    .qry_valid(qry_valid), .qry_ready(qry_ready), .qry_addr(qry_addr),
    .qry_len(qry_len), .res_valid(res_valid), .res_accept(res_accept),
    .res_filt_fail(res_filt_fail), .res_mcast(res_mcast)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input logic [47:0] a, input logic [15:0] len,
                                       input logic pr, input logic ra,
                                       input logic pm, input logic inv);
    logic hit, ff, mf, acc;
    hit = (a == 48'hFFFF_FFFF_FFFF);
    for (int e = 0; e < 16; e++) if (mtab[e] == a) hit = 1'b1;
    ff = pr | ra;
    mf = pm & a[0];
    acc = (hit | ff | mf) ^ inv;
    if (len < 16'd14 || len > 16'd2044) return 3'b000;
    return {acc, ff, mf};
  endfunction

  task automatic query(input string req, input logic [47:0] a, input logic [15:0] len,
                       input logic pr, input logic ra, input logic pm, input logic inv);
    logic [2:0] e;
    @(negedge clk);
    qry_addr = a; qry_len = len; mode_promisc = pr; mode_rx_all = ra;
    mode_pass_mcast = pm; mode_inverse = inv; qry_valid = 1'b1;
    e = model(a, len, pr, ra, pm, inv);
    @(negedge clk);
    qry_valid = 1'b0;
    chk({req, " R10 valid"}, 32'(res_valid), 32'd1);
    chk({req, " result"}, 32'({res_accept, res_filt_fail, res_mcast}), 32'(e));
  endtask

  task automatic load_setup();
    for (int i = 0; i < 192; i++) sf[i] = 8'($urandom);
    for (int n = 0; n < 16; n++)
      mtab[n] = {sf[12*n+9], sf[12*n+8], sf[12*n+5], sf[12*n+4], sf[12*n+1], sf[12*n]};
    for (int i = 0; i < 192; i++) begin
      @(negedge clk);
      setup_valid = 1'b1; setup_data = sf[i];
      if (i == 80) begin
        qry_valid = 1'b1; qry_addr = 48'hFFFF_FFFF_FFFF; qry_len = 16'd64;
        #1 chk("R9 ready low during load", 32'(qry_ready), 32'd0);
      end
      if (i == 81) chk("R9 stalled query gives no result", 32'(res_valid), 32'd0);
      if (i == 82) qry_valid = 1'b0;
    end
    @(negedge clk);
    setup_valid = 1'b0;
    #1 chk("R9 ready after load", 32'(qry_ready), 32'd1);
  endtask

  task automatic random_phase(input int n);
    for (int k = 0; k < n; k++) begin
      logic [47:0] a;
      logic [15:0] len;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 4) a = mtab[$urandom_range(0, 15)];
      else if (sel == 4) a = 48'hFFFF_FFFF_FFFF;
      else if (sel < 7) a = {16'($urandom), 32'($urandom)} | 48'h1;
      else a = {16'($urandom), 32'($urandom)} & ~48'h1;
      sel = $urandom_range(0, 9);
      len = (sel == 0) ? 16'($urandom_range(0, 13)) :
            (sel == 1) ? 16'($urandom_range(2045, 9000)) : 16'($urandom_range(14, 2044));
      query("R2 R4 R5 R6 R8 random", a, len, ($urandom_range(0, 5) == 0),
            ($urandom_range(0, 5) == 0), ($urandom_range(0, 2) == 0),
            ($urandom_range(0, 3) == 0));
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int e = 0; e < 16; e++) mtab[e] = '0;
    repeat (3) @(negedge clk);
    chk("R1 res_valid in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(qry_ready), 32'd1);
    chk("R10 idle no result", 32'(res_valid), 32'd0);
    query("R1 zero address hit", 48'h0, 16'd64, 0, 0, 0, 0);
    query("R2 miss", 48'h0000_0000_0A02, 16'd64, 0, 0, 0, 0);

    load_setup();
    query("R7 entry 0", mtab[0], 16'd64, 0, 0, 0, 0);
    query("R7 entry 15", mtab[15], 16'd100, 0, 0, 0, 0);
    query("R7 padding bytes ignored",
          {sf[11], sf[10], sf[7], sf[6], sf[3], sf[2]} & ~48'h1, 16'd64, 0, 0, 0, 0);
    query("R3 broadcast", 48'hFFFF_FFFF_FFFF, 16'd64, 0, 0, 0, 0);
    query("R4 promisc", 48'h1234_5678_9A02, 16'd64, 1, 0, 0, 0);
    query("R4 rx_all", 48'h1234_5678_9A02, 16'd64, 0, 1, 0, 0);
    query("R5 mcast pass", 48'h1234_5678_9A03, 16'd64, 0, 0, 1, 0);
    query("R5 unicast no flag", 48'h1234_5678_9A02, 16'd64, 0, 0, 1, 0);
    query("R6 inverse miss", 48'h1234_5678_9A02, 16'd64, 0, 0, 0, 1);
    query("R6 inverse hit", mtab[3], 16'd64, 0, 0, 0, 1);
    query("R8 len 13", 48'hFFFF_FFFF_FFFF, 16'd13, 1, 0, 1, 0);
    query("R8 len 14", 48'hFFFF_FFFF_FFFF, 16'd14, 0, 0, 0, 0);
    query("R8 len 2044", mtab[5], 16'd2044, 0, 0, 0, 0);
    query("R8 len 2045 inverse", 48'h1234_5678_9A02, 16'd2045, 0, 0, 0, 1);
    @(negedge clk);
    chk("R10 single-cycle result", 32'(res_valid), 32'd0);
    random_phase(300);

    load_setup();
    query("R7 reload entry 7", mtab[7], 16'd64, 0, 0, 0, 0);
    random_phase(300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule